// File: doc/BRIEF.md
# Per-FET Overcurrent Limiter with Stretched Warning

This block sits between the overcurrent comparators of a three-phase power stage and its gate logic. Each of the six power FETs (a high side and a low side per phase) has its own overcurrent flag and its own gate command. From these, the block produces a blanking mask that the gate logic uses to force individual FETs off. It also drives a warning output and a fault output.

A mode input selects one of two protection behaviours. In limit mode (`latch_mode` = 0), the block works cycle by cycle. A tripped FET is blanked until its own next PWM cycle begins, which is seen as a rising edge of its gate command. Only the warning is raised, and it is held by a stretch timer that restarts each time another FET trips. In latch mode (`latch_mode` = 1), a trip on either FET of a phase blanks both FETs of that phase. The fault is latched and reported on both the fault and the warning outputs, and it is released only by a clear pulse from the enable supervisor once the phase's flags have dropped. The stretch window is a cycle count, `STRETCH_CYCLES`, set so that it equals 64 µs at the block clock.

Top module: `oc_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `fet_block` is all zeros and `warn` and `fault` are low.
- R2: In limit mode, an `oc_flag[i]` that is high at a clock edge sets `fet_block[i]` from the next cycle on. No other bit of `fet_block` changes because of it. Bit 2p is the high-side FET of phase p and bit 2p+1 is the low-side FET.
- R3: A limit-mode blank on FET i is cleared at the first clock edge where `gate_cmd[i]` is high and it was low at the previous edge. If `oc_flag[i]` is also high at that edge, the blank stays set.
- R4: In limit mode, a trip on a FET that is not already blanked raises `warn` in the next cycle. A limit-mode trip never raises `fault`.
- R5: After the last limit-mode trip, `warn` stays high for at most `STRETCH_CYCLES` cycles, even if the blanks remain set.
- R6: A new limit-mode trip on a FET that is not blanked, arriving while the warning is active, restarts the stretch window. `warn` then stays high for `STRETCH_CYCLES` cycles counted from that trip.
- R7: When the last limit-mode blank is cleared by a gate edge, `warn` falls in the same cycle as the blank, unless a phase is latched.
- R8: In latch mode, a high `oc_flag` on either FET of phase p sets both `fet_block[2p]` and `fet_block[2p+1]` from the next cycle. It also raises both `fault` and `warn`.
- R9: A latched phase stays latched across gate edges, across flag release and across mode changes. It is cleared only at an edge where `clr_pulse` is high and both flags of that phase are low. A clear pulse while a flag is still high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| latch_mode | input | 1 | 0 = cycle-by-cycle limit mode, 1 = per-phase latch mode |
| gate_cmd | input | 2*NUM_PHASE | Gate commands; bit 2p is the high side and bit 2p+1 the low side of phase p |
| oc_flag | input | 2*NUM_PHASE | Overcurrent comparator flags, same bit order as the gate commands |
| clr_pulse | input | 1 | Latched-fault clear from the enable supervisor |
| fet_block | output | 2*NUM_PHASE | Per-FET blanking mask, 1 forces the FET off |
| warn | output | 1 | Overcurrent warning, active high |
| fault | output | 1 | Latched shutdown fault, active high |

## Verification
Any wrong state in this block shows up on `fet_block`, `warn` or `fault` within one cycle of the stimulus that exposes it.

- A blank bit that is lost or stuck shows on `fet_block` in the cycle after the trip or after the gate edge that should have cleared it.
- A timer that does not restart, or does not stop, moves the falling edge of `warn` away from the cycle that the requirements fix: `STRETCH_CYCLES` after the last fresh trip, or the cycle in which the last blank clears.
- A phase latch that clears early, or that obeys a clear while its flag is still high, drops `fault` one cycle after the offending edge.

The bench compares all three outputs in every cycle against an independent model.

// File: rtl/oc_guard_pkg.sv
package oc_guard_pkg;

    typedef enum logic {
        MODE_LIMIT = 1'b0,
        MODE_LATCH = 1'b1
    } oc_mode_e;

    typedef struct packed {
        logic gate_prev;
        logic blank;
    } fet_state_t;

    typedef struct packed {
        logic latched;
    } phase_state_t;

endpackage

// File: rtl/oc_fet_limiter.sv
module oc_fet_limiter
    import oc_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic limit_en,
    input  logic gate,
    input  logic oc,
    output logic blank,
    output logic blank_next,
    output logic fresh_trip
);

    fet_state_t st_d, st_q;
    logic       cycle_start;

    always_comb begin
        st_d           = st_q;
        cycle_start    = gate & ~st_q.gate_prev;
        st_d.gate_prev = gate;
        st_d.blank     = (limit_en & oc) | (st_q.blank & ~cycle_start);
        fresh_trip     = limit_en & oc & ~st_q.blank;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign blank      = st_q.blank;
    assign blank_next = st_d.blank;

endmodule

// File: rtl/oc_phase_latch.sv
module oc_phase_latch
    import oc_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic latch_en,
    input  logic oc_hi,
    input  logic oc_lo,
    input  logic clr,
    output logic latched
);

    phase_state_t st_d, st_q;
    logic         any_oc;

    always_comb begin
        st_d   = st_q;
        any_oc = oc_hi | oc_lo;
        if (latch_en && any_oc)  st_d.latched = 1'b1;
        else if (clr && !any_oc) st_d.latched = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched = st_q.latched;

endmodule

// File: rtl/oc_warn_timer.sv
module oc_warn_timer #(
    parameter int unsigned STRETCH_CYCLES = 16000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic hold,
    output logic active
);

    localparam int unsigned CNT_W = $clog2(STRETCH_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] remain;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trip)
            st_d.remain = CNT_W'(STRETCH_CYCLES);
        else if (hold && st_q.remain != '0)
            st_d.remain = st_q.remain - CNT_W'(1);
        else
            st_d.remain = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = (st_q.remain != '0);

endmodule

// File: rtl/oc_guard.sv
module oc_guard
    import oc_guard_pkg::*;
#(
    parameter int unsigned NUM_PHASE      = 3,
    parameter int unsigned STRETCH_CYCLES = 16000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   latch_mode,
    input  logic [2*NUM_PHASE-1:0] gate_cmd,
    input  logic [2*NUM_PHASE-1:0] oc_flag,
    input  logic                   clr_pulse,
    output logic [2*NUM_PHASE-1:0] fet_block,
    output logic                   warn,
    output logic                   fault
);

    localparam int unsigned NUM_FET = 2 * NUM_PHASE;

    oc_mode_e             mode;
    logic [NUM_FET-1:0]   limit_blank;
    logic [NUM_FET-1:0]   limit_blank_next;
    logic [NUM_FET-1:0]   fresh_trip;
    logic [NUM_PHASE-1:0] phase_latched;
    logic [NUM_FET-1:0]   latch_blank;
    logic                 stretch_active;

    assign mode = oc_mode_e'(latch_mode);

    for (genvar f = 0; f < NUM_FET; f++) begin : g_fet
        oc_fet_limiter u_lim (
            .clk        (clk),
            .rst_n      (rst_n),
            .limit_en   (mode == MODE_LIMIT),
            .gate       (gate_cmd[f]),
            .oc         (oc_flag[f]),
            .blank      (limit_blank[f]),
            .blank_next (limit_blank_next[f]),
            .fresh_trip (fresh_trip[f])
        );
    end

    for (genvar p = 0; p < NUM_PHASE; p++) begin : g_phase
        oc_phase_latch u_lat (
            .clk      (clk),
            .rst_n    (rst_n),
            .latch_en (mode == MODE_LATCH),
            .oc_hi    (oc_flag[2*p]),
            .oc_lo    (oc_flag[2*p+1]),
            .clr      (clr_pulse),
            .latched  (phase_latched[p])
        );
        assign latch_blank[2*p]   = phase_latched[p];
        assign latch_blank[2*p+1] = phase_latched[p];
    end

    oc_warn_timer #(
        .STRETCH_CYCLES (STRETCH_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .trip   (|fresh_trip),
        .hold   (|limit_blank_next),
        .active (stretch_active)
    );

    always_comb begin
        fet_block = limit_blank | latch_blank;
        fault     = |phase_latched;
        warn      = stretch_active | fault;
    end

endmodule

// File: rtl/oc_guard_chk.sv
module oc_guard_chk #(
    parameter int unsigned NUM_PHASE = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   latch_mode,
    input logic [2*NUM_PHASE-1:0] oc_flag,
    input logic                   clr_pulse,
    input logic [2*NUM_PHASE-1:0] fet_block,
    input logic                   warn,
    input logic                   fault
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fet_block == '0 && !warn && !fault));

    for (genvar f = 0; f < 2*NUM_PHASE; f++) begin : g_fet_chk
        assert_limit_blank_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!latch_mode && oc_flag[f]) |=> fet_block[f]);
    end

    assert_limit_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_mode && |(oc_flag & ~fet_block)) |=> warn);

    for (genvar p = 0; p < NUM_PHASE; p++) begin : g_phase_chk
        assert_phase_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_mode && (oc_flag[2*p] || oc_flag[2*p+1]))
            |=> (fet_block[2*p] && fet_block[2*p+1] && fault));
    end

    assert_fault_warns_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> warn);

    assert_latch_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !clr_pulse) |=> fault);

endmodule

bind oc_guard oc_guard_chk #(
    .NUM_PHASE (NUM_PHASE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .latch_mode (latch_mode),
    .oc_flag    (oc_flag),
    .clr_pulse  (clr_pulse),
    .fet_block  (fet_block),
    .warn       (warn),
    .fault      (fault)
);

// File: tb/oc_guard_tb.sv
`timescale 1ns/1ps
module oc_guard_tb;

    localparam int NP = 3;
    localparam int NF = 2 * NP;
    localparam int S  = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          latch_mode = 1'b0;
    logic [NF-1:0] gate_cmd = '0;
    logic [NF-1:0] oc_flag = '0;
    logic          clr_pulse = 1'b0;
    logic [NF-1:0] fet_block;
    logic          warn;
    logic          fault;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    logic [NF-1:0] m_gprev = '0;
    logic [NF-1:0] m_blank = '0;
    logic [NP-1:0] m_lat = '0;
    int            m_cnt = 0;

    oc_guard #(.NUM_PHASE(NP), .STRETCH_CYCLES(S)) u_dut (
        .clk(clk), .rst_n(rst_n), .latch_mode(latch_mode), .gate_cmd(gate_cmd),
        .oc_flag(oc_flag), .clr_pulse(clr_pulse), .fet_block(fet_block),
        .warn(warn), .fault(fault)
    );

    always #2 clk = ~clk;

    function automatic logic [NF-1:0] exp_block();
        logic [NF-1:0] b = m_blank;
        for (int p = 0; p < NP; p++) begin
            if (m_lat[p]) begin
                b[2*p] = 1'b1;
                b[2*p+1] = 1'b1;
            end
        end
        return b;
    endfunction

    function automatic logic exp_warn();
        return (m_cnt != 0) || (m_lat != '0);
    endfunction

    task automatic model_edge();
        logic [NF-1:0] nb;
        logic          fresh;
        if (!rst_n) begin
            m_gprev = '0; m_blank = '0; m_lat = '0; m_cnt = 0;
            return;
        end
        fresh = 1'b0;
        for (int i = 0; i < NF; i++) begin
            nb[i] = (!latch_mode && oc_flag[i]) || (m_blank[i] && !(gate_cmd[i] && !m_gprev[i]));
            if (!latch_mode && oc_flag[i] && !m_blank[i]) fresh = 1'b1;
        end
        for (int p = 0; p < NP; p++) begin
            if (latch_mode && (oc_flag[2*p] || oc_flag[2*p+1])) m_lat[p] = 1'b1;
            else if (clr_pulse && !(oc_flag[2*p] || oc_flag[2*p+1])) m_lat[p] = 1'b0;
        end
        if (fresh) m_cnt = S;
        else if (m_cnt != 0 && nb != '0) m_cnt = m_cnt - 1;
        else m_cnt = 0;
        m_blank = nb;
        m_gprev = gate_cmd;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(cur_req, "fet_block", int'(fet_block), int'(exp_block()));
        chk(cur_req, "warn", int'(warn), int'(exp_warn()));
        chk(cur_req, "fault", int'(fault), int'(m_lat != '0));
    endtask

    task automatic quiet();
        oc_flag = '0; clr_pulse = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        int cnt;
        int seed;
        seed = $urandom(32'h0C6A_1D5E);

        // R1: reset state
        cur_req = "R1";
        repeat (3) step();
        @(negedge clk) rst_n = 1'b1;
        step();
        chk("R1", "block after reset", int'(fet_block), 0);

        // R2 / R4: one limit trip on FET 2 only
        cur_req = "R2";
        latch_mode = 1'b0; gate_cmd = '0;
        oc_flag = 6'b000100;
        step();
        quiet();
        chk("R2", "only FET2 blanked", int'(fet_block), 6'b000100);
        chk("R4", "warn after trip", int'(warn), 1);
        chk("R4", "no fault in limit", int'(fault), 0);

        // R5: warn length bounded while blank persists
        cur_req = "R5";
        cnt = 1;
        while (warn && cnt < 3*S) begin step(); if (warn) cnt++; end
        chk("R5", "warn length", cnt, S);
        chk("R5", "blank kept", int'(fet_block), 6'b000100);

        // R3: rising gate clears blank, coincident trip keeps it
        cur_req = "R3";
        gate_cmd[2] = 1'b1; step();
        chk("R3", "cleared by gate edge", int'(fet_block[2]), 0);
        gate_cmd[2] = 1'b0; oc_flag[2] = 1'b1; step(); quiet();
        gate_cmd[2] = 1'b1; oc_flag[2] = 1'b1; step(); quiet();
        chk("R3", "coincident trip keeps blank", int'(fet_block[2]), 1);
        gate_cmd = '0;
        step();

        // R6: second trip restarts the window
        cur_req = "R6";
        gate_cmd[2] = 1'b1; step(); gate_cmd = '0; step();
        oc_flag[0] = 1'b1; step(); quiet();
        repeat (5) step();
        oc_flag[3] = 1'b1; step(); quiet();
        cnt = 1;
        while (warn && cnt < 3*S) begin step(); if (warn) cnt++; end
        chk("R6", "warn after restart", cnt, S);

        // R7: warn falls with the last blank
        cur_req = "R7";
        gate_cmd = 6'b001001; step();
        gate_cmd = '0;
        oc_flag[1] = 1'b1; step(); quiet();
        step();
        gate_cmd[1] = 1'b1; step();
        chk("R7", "block clear", int'(fet_block), 0);
        chk("R7", "warn falls", int'(warn), 0);
        gate_cmd = '0; step();

        // R8 / R9: latch on phase 2, clear attempts
        cur_req = "R8";
        latch_mode = 1'b1;
        oc_flag[4] = 1'b1; step();
        chk("R8", "phase blank", int'(fet_block), 6'b110000);
        chk("R8", "fault", int'(fault), 1);
        chk("R8", "warn", int'(warn), 1);
        cur_req = "R9";
        clr_pulse = 1'b1; step();
        chk("R9", "clear ignored with flag", int'(fault), 1);
        quiet(); latch_mode = 1'b0;
        gate_cmd = 6'b110000; step(); gate_cmd = '0; step();
        chk("R9", "latch kept", int'(fet_block), 6'b110000);
        clr_pulse = 1'b1; step(); quiet();
        chk("R9", "cleared", int'(fault), 0);
        chk("R9", "unblocked", int'(fet_block), 0);

        // random mix of modes, trips, gate edges and clears
        for (int blk = 0; blk < 8; blk++) begin
            latch_mode = blk[0];
            cur_req = latch_mode ? "R8" : "R2";
            for (int n = 0; n < 400; n++) begin
                for (int i = 0; i < NF; i++) begin
                    oc_flag[i] = ($urandom_range(0, 24) == 0);
                    if ($urandom_range(0, 5) == 0) gate_cmd[i] = ~gate_cmd[i];
                end
                clr_pulse = ($urandom_range(0, 9) == 0);
                step();
            end
        end
        quiet();
        step();
        finish_run();
    end

endmodule